// File: doc/BRIEF.md
# Dual-Strobe Parallel Host Port

This block is an 8-bit slave port that an external host processor uses to reach a small bank of byte registers. Three host address lines pick the register. An active-low host select gates every access. The host pins are sampled through synchronizers into the internal clock domain. A host write takes effect when its strobe ends. A read drives the data bus while its strobe is active.

Two shared host pins carry the strobes, and a static mode input sets how they are read. In single-strobe style, pin A is read/not-write and pin B is an active-low data strobe. In double-strobe style, pin A is an active-low read strobe and pin B is an active-low write strobe. A second mode input sets the request signalling. In combined mode, one open-drain request line is used, and an acknowledge input lets the host reach the data register without the select or the address. In split mode, there are two open-drain lines: a transmit request and a receive request.

On the internal side there are two one-byte mailboxes. The core loads the send-to-host byte. The core pops the byte received from the host. A host read that empties the send-to-host mailbox raises a one-cycle transmit-empty interrupt.

Top module: `hport_top`

## Requirements
- R1: While reset is asserted, the port drives nothing toward the host: data output enable and both request enables are low, and both mailboxes are empty.
- R2: In single-strobe style (dual mode input 0), a write is a strobe with select low, pin A low and pin B low. The byte on the data inputs is stored into the addressed register after pin B returns high.
- R3: In single-strobe style, select low with pin A high and pin B low is a read. The port drives the data output enable and presents the addressed register. With select high, a strobe neither drives the bus nor changes any register.
- R4: In double-strobe style (dual mode input 1), pin A low with select low reads, and pin B low with select low writes. The same register bank is reachable as in R2 and R3.
- R5: A host write to address 0 fills the receive-from-host mailbox and raises core_h2c_full only when that mailbox is empty. A write to address 0 while it is full leaves the held byte unchanged.
- R6: A core load fills the send-to-host mailbox only when it is empty. A host read of address 0 returns that byte, empties the mailbox, and pulses core_tx_empty_irq for one cycle. A read of address 0 while that mailbox is empty gives no pulse.
- R7: Address 1 is a read-only status byte. Bit 0 is 1 when the send-to-host mailbox is full. Bit 1 is 1 when the receive-from-host mailbox is full. The other bits are 0. Host writes to address 1 have no effect.
- R8: Addresses 2 to 7 are general byte registers. They reset to 0 and read back the last value the host wrote to them.
- R9: In combined request mode (split input 0), host_req_oe is high while the receive-from-host mailbox is empty or the send-to-host mailbox is full, and host_rrq_oe stays low.
- R10: In split request mode (split input 1), host_req_oe is high exactly while the receive-from-host mailbox is empty, and host_rrq_oe is high exactly while the send-to-host mailbox is full.
- R11: In combined mode, host_ack_n low with a read or write strobe reaches address 0 whatever the select and address lines hold. In split mode, host_ack_n is ignored.
- R12: core_h2c_pop empties the receive-from-host mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual_strobe | input | 1 | 0: single-strobe style, 1: double-strobe style |
| cfg_split_req | input | 1 | 0: combined request with acknowledge, 1: split requests |
| host_cs_n | input | 1 | Host select, active low |
| host_addr | input | 3 | Host register address |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_dout_oe | output | 1 | Drive enable for host read data |
| host_pin_a | input | 1 | Read/not-write, or read strobe (active low) |
| host_pin_b | input | 1 | Data strobe, or write strobe (both active low) |
| host_ack_n | input | 1 | Host acknowledge, active low, combined mode only |
| host_req_oe | output | 1 | Pulls the request line (or the transmit request line) low |
| host_rrq_oe | output | 1 | Pulls the receive request line low, split mode only |
| core_c2h_data | input | 8 | Byte the core sends to the host |
| core_c2h_load | input | 1 | Load strobe for core_c2h_data |
| core_h2c_data | output | 8 | Byte received from the host |
| core_h2c_full | output | 1 | Receive-from-host mailbox holds a byte |
| core_h2c_pop | input | 1 | Empties the receive-from-host mailbox |
| core_tx_empty_irq | output | 1 | One-cycle pulse when a host read empties the send-to-host mailbox |

## Verification
The hardest cases to reach are the ones where the mailboxes refuse an update. A host write must land while the receive mailbox is still full, and a core load must come while the send mailbox is still full. A second case is the acknowledge path in split mode, where the request pin is an output, so the acknowledge has to be shown to do nothing. The stimulus fills each mailbox first and then repeats the access. It reads the held byte back through the data port or the core port, and reads the status byte to show the flags did not move. For the acknowledge case, it makes an acknowledged read with the select high in both request modes and compares the interrupt count and the status byte.

// File: rtl/hport_pkg.sv
package hport_pkg;
  // Host-visible address map; the status bit order is observed by the host.
  localparam int unsigned HP_ADR_DATA = 0;
  localparam int unsigned HP_ADR_STAT = 1;
  localparam int unsigned HP_ADR_GEN0 = 2;

  // Synchronized host control pins, packed in synchronizer order.
  typedef struct packed {
    logic cs_n;
    logic pin_a;
    logic pin_b;
    logic ack_n;
  } hp_pins_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int unsigned      WIDTH   = 4,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= RST_VAL;
        else        stg_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hport_decode.sv
module hport_decode
  import hport_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              dual_strobe,
  input  logic              split_req,
  input  hp_pins_t          pins,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_act,
  output logic              wr_act,
  output logic [ADDR_W-1:0] addr_eff
);
  logic ack_sel;
  logic sel;
  logic strobe;

  always_comb begin
    ack_sel  = !split_req && !pins.ack_n;
    sel      = !pins.cs_n || ack_sel;
    strobe   = sel && !pins.pin_b;
    if (dual_strobe) begin
      // read strobe wins if both strobes are low together
      rd_act = sel && !pins.pin_a;
      wr_act = sel && !pins.pin_b && pins.pin_a;
    end else begin
      rd_act = strobe && pins.pin_a;
      wr_act = strobe && !pins.pin_a;
    end
    addr_eff = ack_sel ? ADDR_W'(HP_ADR_DATA) : addr_in;
  end
endmodule

// File: rtl/hport_regs.sv
module hport_regs
  import hport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_commit,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] cm_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              core_load,
  input  logic [DATA_W-1:0] core_data,
  input  logic              core_pop,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] h2c_byte,
  output logic              h2c_full,
  output logic [DATA_W-1:0] c2h_byte,
  output logic              c2h_full,
  output logic              irq
);
  localparam int unsigned NREG  = 1 << ADDR_W;
  localparam int unsigned NGEN  = NREG - HP_ADR_GEN0;
  localparam int unsigned GEN_W = (NGEN > 1) ? $clog2(NGEN) : 1;

  logic [DATA_W-1:0] gen_q [NGEN];
  logic [DATA_W-1:0] gen_n [NGEN];
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic [DATA_W-1:0] h2c_byte_q, h2c_byte_n, c2h_byte_q, c2h_byte_n;
  logic              h2c_full_q, h2c_full_n, c2h_full_q, c2h_full_n;
  logic              irq_q, irq_n;
  logic [GEN_W-1:0]  wr_idx, rd_idx;
  logic [ADDR_W-1:0] wr_off, rd_off;

  always_comb begin
    wr_off = cm_addr - ADDR_W'(HP_ADR_GEN0);
    rd_off = rd_addr - ADDR_W'(HP_ADR_GEN0);
    wr_idx = GEN_W'(wr_off);
    rd_idx = GEN_W'(rd_off);
  end

  always_comb begin
    gen_n      = gen_q;
    rdata_n    = rdata_q;
    h2c_byte_n = h2c_byte_q;
    h2c_full_n = h2c_full_q;
    c2h_byte_n = c2h_byte_q;
    c2h_full_n = c2h_full_q;
    irq_n      = 1'b0;

    if (core_pop) h2c_full_n = 1'b0;
    if (core_load && !c2h_full_q) begin
      c2h_full_n = 1'b1;
      c2h_byte_n = core_data;
    end

    if (wr_commit) begin
      if (cm_addr == ADDR_W'(HP_ADR_DATA)) begin
        if (!h2c_full_q) begin
          h2c_full_n = 1'b1;
          h2c_byte_n = wdata;
        end
      end else if (cm_addr != ADDR_W'(HP_ADR_STAT)) begin
        gen_n[wr_idx] = wdata;
      end
    end

    if (rd_commit && (cm_addr == ADDR_W'(HP_ADR_DATA)) && c2h_full_q) begin
      c2h_full_n = 1'b0;
      irq_n      = 1'b1;
    end

    if (rd_act) begin
      if (rd_addr == ADDR_W'(HP_ADR_DATA))      rdata_n = c2h_byte_q;
      else if (rd_addr == ADDR_W'(HP_ADR_STAT)) rdata_n = {{(DATA_W-2){1'b0}}, h2c_full_q, c2h_full_q};
      else                                      rdata_n = gen_q[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NGEN; i++) gen_q[i] <= '0;
      rdata_q    <= '0;
      h2c_byte_q <= '0;
      h2c_full_q <= 1'b0;
      c2h_byte_q <= '0;
      c2h_full_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      gen_q      <= gen_n;
      rdata_q    <= rdata_n;
      h2c_byte_q <= h2c_byte_n;
      h2c_full_q <= h2c_full_n;
      c2h_byte_q <= c2h_byte_n;
      c2h_full_q <= c2h_full_n;
      irq_q      <= irq_n;
    end
  end

  assign rdata    = rdata_q;
  assign h2c_byte = h2c_byte_q;
  assign h2c_full = h2c_full_q;
  assign c2h_byte = c2h_byte_q;
  assign c2h_full = c2h_full_q;
  assign irq      = irq_q;
endmodule

// File: rtl/hport_top.sv
module hport_top
  import hport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual_strobe,
  input  logic              cfg_split_req,
  input  logic              host_cs_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_oe,
  input  logic              host_pin_a,
  input  logic              host_pin_b,
  input  logic              host_ack_n,
  output logic              host_req_oe,
  output logic              host_rrq_oe,
  input  logic [DATA_W-1:0] core_c2h_data,
  input  logic              core_c2h_load,
  output logic [DATA_W-1:0] core_h2c_data,
  output logic              core_h2c_full,
  input  logic              core_h2c_pop,
  output logic              core_tx_empty_irq
);
  localparam int unsigned PIN_W = $bits(hp_pins_t);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [PIN_W-1:0] pins_raw, pins_sync;
  hp_pins_t         pins_s;
  assign pins_raw = {host_cs_n, host_pin_a, host_pin_b, host_ack_n};

  hport_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL({PIN_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pins_raw), .q(pins_sync)
  );
  assign pins_s = hp_pins_t'(pins_sync);

  logic              rd_act, wr_act;
  logic [ADDR_W-1:0] addr_eff;

  hport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .dual_strobe(cfg_dual_strobe), .split_req(cfg_split_req), .pins(pins_s),
    .addr_in(host_addr), .rd_act(rd_act), .wr_act(wr_act), .addr_eff(addr_eff)
  );

  logic              rd_act_q, wr_act_q, oe_q, req_a_q, req_b_q;
  logic              oe_n, req_a_n, req_b_n;
  logic [ADDR_W-1:0] hold_addr_q, hold_addr_n;
  logic [DATA_W-1:0] hold_data_q, hold_data_n;
  logic              rd_commit, wr_commit;
  logic [DATA_W-1:0] rdata, c2h_byte, h2c_byte;
  logic              h2c_full, c2h_full, irq;

  assign rd_commit = rd_act_q && !rd_act;
  assign wr_commit = wr_act_q && !wr_act;

  hport_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .rd_act(rd_act), .rd_addr(addr_eff), .rd_commit(rd_commit),
    .wr_commit(wr_commit), .cm_addr(hold_addr_q), .wdata(hold_data_q),
    .core_load(core_c2h_load), .core_data(core_c2h_data), .core_pop(core_h2c_pop),
    .rdata(rdata), .h2c_byte(h2c_byte), .h2c_full(h2c_full),
    .c2h_byte(c2h_byte), .c2h_full(c2h_full), .irq(irq)
  );

  always_comb begin
    hold_addr_n = hold_addr_q;
    hold_data_n = hold_data_q;
    if (rd_act || wr_act) hold_addr_n = addr_eff;
    if (wr_act)           hold_data_n = host_din;
    oe_n    = rd_act;
    req_a_n = cfg_split_req ? !h2c_full : (!h2c_full || c2h_full);
    req_b_n = cfg_split_req && c2h_full;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_act_q    <= 1'b0;
      wr_act_q    <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
      oe_q        <= 1'b0;
      req_a_q     <= 1'b0;
      req_b_q     <= 1'b0;
    end else begin
      rd_act_q    <= rd_act;
      wr_act_q    <= wr_act;
      hold_addr_q <= hold_addr_n;
      hold_data_q <= hold_data_n;
      oe_q        <= oe_n;
      req_a_q     <= req_a_n;
      req_b_q     <= req_b_n;
    end
  end

  assign host_dout         = rdata;
  assign host_dout_oe      = oe_q;
  assign host_req_oe       = req_a_q;
  assign host_rrq_oe       = req_b_q;
  assign core_h2c_data     = h2c_byte;
  assign core_h2c_full     = h2c_full;
  assign core_tx_empty_irq = irq;
endmodule

// File: rtl/hport_chk.sv
module hport_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_split_req,
  input logic              host_rrq_oe,
  input logic [DATA_W-1:0] core_h2c_data,
  input logic              core_h2c_full,
  input logic              core_h2c_pop,
  input logic              core_c2h_load,
  input logic              c2h_full,
  input logic [DATA_W-1:0] c2h_byte,
  input logic              irq
);
  // R9: combined mode never pulls the second request line
  p_rrq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_split_req && !$past(cfg_split_req)) |-> !host_rrq_oe);

  // R6: interrupt lasts one cycle
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: interrupt only follows a full send mailbox
  p_irq_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(c2h_full));

  // R6: a load into a full send mailbox keeps the held byte
  p_c2h_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_full && core_c2h_load) |=> $stable(c2h_byte));

  // R5: a full receive mailbox holds until popped
  p_h2c_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_h2c_full && !core_h2c_pop) |=> (core_h2c_full && $stable(core_h2c_data)));
endmodule

bind hport_top hport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_split_req(cfg_split_req),
  .host_rrq_oe(host_rrq_oe), .core_h2c_data(core_h2c_data),
  .core_h2c_full(core_h2c_full), .core_h2c_pop(core_h2c_pop),
  .core_c2h_load(core_c2h_load), .c2h_full(c2h_full),
  .c2h_byte(c2h_byte), .irq(irq)
);

// File: tb/tb_hport_top.sv
module tb_hport_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_dual_strobe, cfg_split_req;
  logic       host_cs_n, host_pin_a, host_pin_b, host_ack_n;
  logic [2:0] host_addr;
  logic [7:0] host_din, host_dout;
  logic       host_dout_oe, host_req_oe, host_rrq_oe;
  logic [7:0] core_c2h_data, core_h2c_data;
  logic       core_c2h_load, core_h2c_full, core_h2c_pop, core_tx_empty_irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  hport_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_dual_strobe(cfg_dual_strobe), .cfg_split_req(cfg_split_req),
    .host_cs_n(host_cs_n), .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
    .host_dout_oe(host_dout_oe), .host_pin_a(host_pin_a), .host_pin_b(host_pin_b),
    .host_ack_n(host_ack_n), .host_req_oe(host_req_oe), .host_rrq_oe(host_rrq_oe),
    .core_c2h_data(core_c2h_data), .core_c2h_load(core_c2h_load), .core_h2c_data(core_h2c_data),
    .core_h2c_full(core_h2c_full), .core_h2c_pop(core_h2c_pop), .core_tx_empty_irq(core_tx_empty_irq)
  );

  always @(posedge clk) if (core_tx_empty_irq === 1'b1) irq_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one host access; in single-strobe style pin A is set before and released after pin B
  task automatic host_xfer(input bit is_rd, input logic [2:0] a, input logic [7:0] d,
                           input bit use_cs, input bit use_ack,
                           output logic [7:0] q, output logic oe);
    host_addr = a; host_din = d;
    host_cs_n = !use_cs; host_ack_n = !use_ack;
    if (!cfg_dual_strobe) host_pin_a = is_rd;
    cyc(1);
    if (cfg_dual_strobe) begin
      if (is_rd) host_pin_a = 1'b0; else host_pin_b = 1'b0;
    end else host_pin_b = 1'b0;
    cyc(5);
    q = host_dout; oe = host_dout_oe;
    host_pin_b = 1'b1;
    if (cfg_dual_strobe) host_pin_a = 1'b1;
    cyc(1);
    host_pin_a = 1'b1;
    cyc(5);
    host_cs_n = 1'b1; host_ack_n = 1'b1;
    cyc(2);
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q; logic oe;
    host_xfer(1'b0, a, d, 1'b1, 1'b0, q, oe);
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] q, output logic oe);
    host_xfer(1'b1, a, 8'h00, 1'b1, 1'b0, q, oe);
  endtask

  task automatic core_load(input logic [7:0] d);
    core_c2h_data = d; core_c2h_load = 1'b1;
    cyc(1);
    core_c2h_load = 1'b0;
    cyc(2);
  endtask

  task automatic core_pop();
    core_h2c_pop = 1'b1;
    cyc(1);
    core_h2c_pop = 1'b0;
    cyc(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(3);
    chk(!host_dout_oe && !host_req_oe && !host_rrq_oe, "R1 drives in reset",
        {host_dout_oe, host_req_oe, host_rrq_oe}, 0);
    chk(!core_h2c_full, "R1 mailbox empty", core_h2c_full, 0);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_general_regs();
    logic [7:0] q; logic oe;
    hwr(3'd3, 8'hA5);
    hwr(3'd7, 8'h5A);
    hrd(3'd3, q, oe);
    chk(oe === 1'b1, "R3 read drives bus", oe, 1);
    chk(q === 8'hA5, "R2 R8 addr3 readback", q, 8'hA5);
    hrd(3'd7, q, oe);
    chk(q === 8'h5A, "R8 addr7 readback", q, 8'h5A);
    hrd(3'd4, q, oe);
    chk(q === 8'h00, "R8 addr4 reset value", q, 0);
  endtask

  task automatic t_no_select();
    logic [7:0] q; logic oe;
    host_xfer(1'b1, 3'd3, 8'h00, 1'b0, 1'b0, q, oe);
    chk(oe === 1'b0, "R3 no drive without select", oe, 0);
    host_xfer(1'b0, 3'd3, 8'h11, 1'b0, 1'b0, q, oe);
    hrd(3'd3, q, oe);
    chk(q === 8'hA5, "R3 write without select ignored", q, 8'hA5);
  endtask

  task automatic t_h2c();
    logic [7:0] q; logic oe;
    hwr(3'd0, 8'h77);
    chk(core_h2c_full === 1'b1, "R5 full after write", core_h2c_full, 1);
    chk(core_h2c_data === 8'h77, "R5 received byte", core_h2c_data, 8'h77);
    hrd(3'd1, q, oe);
    chk(q === 8'h02, "R7 status h2c full", q, 8'h02);
    hwr(3'd0, 8'h88);
    chk(core_h2c_data === 8'h77, "R5 write while full ignored", core_h2c_data, 8'h77);
    core_pop();
    chk(core_h2c_full === 1'b0, "R12 pop empties", core_h2c_full, 0);
    hwr(3'd1, 8'hFF);
    hrd(3'd1, q, oe);
    chk(q === 8'h00, "R7 status write ignored", q, 0);
  endtask

  task automatic t_c2h();
    logic [7:0] q; logic oe; int base;
    core_load(8'h3C);
    core_load(8'h99);
    hrd(3'd1, q, oe);
    chk(q === 8'h01, "R7 status c2h full", q, 8'h01);
    base = irq_cnt;
    hrd(3'd0, q, oe);
    chk(q === 8'h3C, "R6 load while full ignored", q, 8'h3C);
    chk(irq_cnt == base + 1, "R6 one interrupt pulse", irq_cnt - base, 1);
    hrd(3'd1, q, oe);
    chk(q === 8'h00, "R6 read empties mailbox", q, 0);
    base = irq_cnt;
    hrd(3'd0, q, oe);
    chk(irq_cnt == base, "R6 no pulse when empty", irq_cnt - base, 0);
  endtask

  task automatic t_dual();
    logic [7:0] q; logic oe;
    cfg_dual_strobe = 1'b1;
    cyc(2);
    hwr(3'd5, 8'hC3);
    hrd(3'd5, q, oe);
    chk(oe === 1'b1 && q === 8'hC3, "R4 double-strobe write/read", q, 8'hC3);
    hrd(3'd3, q, oe);
    chk(q === 8'hA5, "R4 same bank", q, 8'hA5);
    cfg_dual_strobe = 1'b0;
    cyc(2);
  endtask

  task automatic t_requests();
    logic [7:0] q; logic oe;
    chk(host_req_oe === 1'b1 && host_rrq_oe === 1'b0, "R9 both empty",
        {host_req_oe, host_rrq_oe}, 2'b10);
    hwr(3'd0, 8'h12);
    chk(host_req_oe === 1'b0, "R9 h2c full c2h empty", host_req_oe, 0);
    core_load(8'h34);
    chk(host_req_oe === 1'b1 && host_rrq_oe === 1'b0, "R9 c2h full",
        {host_req_oe, host_rrq_oe}, 2'b10);
    cfg_split_req = 1'b1;
    cyc(2);
    chk(host_req_oe === 1'b0 && host_rrq_oe === 1'b1, "R10 h2c full c2h full",
        {host_req_oe, host_rrq_oe}, 2'b01);
    core_pop();
    hrd(3'd0, q, oe);
    chk(host_req_oe === 1'b1 && host_rrq_oe === 1'b0, "R10 both empty",
        {host_req_oe, host_rrq_oe}, 2'b10);
    cfg_split_req = 1'b0;
    cyc(2);
  endtask

  task automatic t_ack();
    logic [7:0] q; logic oe; int base;
    core_load(8'h42);
    base = irq_cnt;
    host_xfer(1'b1, 3'd6, 8'h00, 1'b0, 1'b1, q, oe);
    chk(oe === 1'b1 && q === 8'h42, "R11 ack reads data reg", q, 8'h42);
    chk(irq_cnt == base + 1, "R11 ack read empties", irq_cnt - base, 1);
    cfg_split_req = 1'b1;
    cyc(2);
    core_load(8'h43);
    base = irq_cnt;
    host_xfer(1'b1, 3'd6, 8'h00, 1'b0, 1'b1, q, oe);
    chk(oe === 1'b0, "R11 ack ignored in split", oe, 0);
    hrd(3'd1, q, oe);
    chk(q === 8'h01 && irq_cnt == base, "R11 split ack left mailbox full", q, 8'h01);
    cfg_split_req = 1'b0;
    cyc(2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cfg_dual_strobe = 1'b0; cfg_split_req = 1'b0;
    host_cs_n = 1'b1; host_pin_a = 1'b1; host_pin_b = 1'b1; host_ack_n = 1'b1;
    host_addr = '0; host_din = '0;
    core_c2h_data = '0; core_c2h_load = 1'b0; core_h2c_pop = 1'b0;
    cyc(1);
    t_reset();
    t_general_regs();
    t_no_select();
    t_h2c();
    t_c2h();
    t_dual();
    t_requests();
    t_ack();
    summary();
  end
endmodule